// File: doc/BRIEF.md
# Burst Memory Slave for a Pipelined Register Bus

This block is a small on-chip word memory that sits as a slave on a pipelined register bus with bursts. A master moves 32-bit words in and out of it. A write burst presents one word per accepted write strobe. A read burst is started by a single accepted read strobe and is answered later by a train of data-valid beats, one per word. The slave stalls the master with a wait-request signal. A strobe only takes effect in a cycle where wait-request is low.

Read requests are queued in a small in-order request queue, so several read bursts can be in flight at once. Their data returns strictly in request order. The start address and the burst length are captured on the first accepted strobe of each burst. After that, the slave steps the address itself, and the address wraps at the top of the memory. Writes carry a per-byte enable mask.

Top module: `pbus_burst_ram`

## Requirements
- R1: On a write burst, `bus_addr` and `bus_burst` are sampled only on the first accepted write strobe. Accepted write number i (counting from 0) stores its word at start+i. The burst ends after exactly `bus_burst` accepted strobes, and the next accepted write strobe starts a new burst.
- R2: `bus_byte_en` bit b gates data bits 8b+7..8b of the written word. A byte whose enable bit is 0 keeps its old content.
- R3: An accepted read strobe with start A and length N yields N `bus_rvalid` beats carrying the words at A, A+1, …, A+N-1. When the slave is idle, the first beat is visible in the cycle after the second rising edge that follows the accepting edge. The beats of one burst come on consecutive cycles.
- R4: Up to FIFO_DEPTH accepted read requests wait in a queue behind the one being served. Their data returns in request order, with one idle cycle between consecutive bursts. A read strobe sees `bus_wait` high while the queue is full.
- R5: A read strobe sees `bus_wait` high while a write burst is unfinished. A write strobe that would start a new burst sees `bus_wait` high while any read is queued or being served.
- R6: A `bus_burst` value of 0 is handled exactly like 1, for both reads and writes.
- R7: Burst addresses wrap modulo DEPTH (a power of two), so the word after DEPTH-1 is word 0.
- R8: Synchronous active-high `rst` clears `bus_rvalid`, drops all queued and partly served reads, and aborts a partial write burst. It leaves the memory contents untouched.
- R9: Out of reset, with no strobes present, `bus_wait` and `bus_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | $clog2(DEPTH) | Word address, used on the first strobe of a burst |
| bus_burst | input | BURST_W | Burst length in words, 0 means 1 |
| bus_read | input | 1 | Read strobe |
| bus_write | input | 1 | Write strobe, never together with bus_read |
| bus_wdata | input | 32 | Write data |
| bus_byte_en | input | 4 | Byte lane enables for the write data |
| bus_wait | output | 1 | Stall: strobes are ignored while high |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One pulse per returned read word |

## Verification
A write takes effect at the edge that accepts it. It is observed through a later read burst, whose first beat is due exactly two edges after the read is accepted when the slave is idle; each further beat follows one edge later, and the next queued burst follows after a single idle cycle. Wait-request is a function of the current strobes and state, so it is judged a moment after each strobe is driven, before the next edge. The bench drives on the falling edge, samples on the falling edge, and stamps every data-valid beat with its edge number, so these latencies are compared as exact cycle counts. Sweeps cover all sixteen byte-enable masks, a full-memory fill and read back, wrap-around, zero-length bursts, a full request queue, and resets in the middle of reads and writes.

// File: rtl/pbr_pkg.sv
`timescale 1ns/1ps
package pbr_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;
endpackage

// File: rtl/pbr_mem.sv
`timescale 1ns/1ps
// Simple dual-port word memory with byte lanes, registered read (block RAM style).
module pbr_mem #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  pbr_pkg::word_t    wdata,
  input  pbr_pkg::lane_t    wlanes,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output pbr_pkg::word_t    rdata
);
  import pbr_pkg::*;

  logic [LANES-1:0][7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < LANES; b++) begin
        if (wlanes[b]) begin
          store[waddr][b] <= wdata[8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= store[raddr];
    end
  end
endmodule

// File: rtl/pbr_req_fifo.sv
`timescale 1ns/1ps
// In-order queue of pending read requests.
module pbr_req_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] used;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty = (used == '0);
  assign full  = (used == CW'(DEPTH));
  assign dout  = slots[rptr];

  always_ff @(posedge clk) begin
    if (push) begin
      slots[wptr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      used <= '0;
    end else begin
      if (push) begin
        wptr <= step(wptr);
      end
      if (pop) begin
        rptr <= step(rptr);
      end
      case ({push, pop})
        2'b10:   used <= used + CW'(1);
        2'b01:   used <= used - CW'(1);
        default: used <= used;
      endcase
    end
  end

  // R4
  fifo_ovf_chk: assert property (@(posedge clk) disable iff (rst) !(push && full));
  // R4
  fifo_unf_chk: assert property (@(posedge clk) disable iff (rst) !(pop && empty));
endmodule

// File: rtl/pbr_wr_ctrl.sv
`timescale 1ns/1ps
// Write burst tracker: captures start and length on the first beat, then steps.
module pbr_wr_ctrl #(
  parameter int AW      = 6,
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [AW-1:0]      addr,
  input  logic [BURST_W-1:0] burst,
  output logic [AW-1:0]      beat_addr,
  output logic               in_burst
);
  logic [AW-1:0]      next_addr;
  logic [BURST_W-1:0] left;
  logic [BURST_W-1:0] len;

  assign len       = (burst == '0) ? BURST_W'(1) : burst;
  assign beat_addr = in_burst ? next_addr : addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_burst  <= 1'b0;
      next_addr <= '0;
      left      <= '0;
    end else if (fire) begin
      next_addr <= beat_addr + AW'(1);
      if (!in_burst) begin
        left     <= len - BURST_W'(1);
        in_burst <= (len > BURST_W'(1));
      end else begin
        left <= left - BURST_W'(1);
        if (left == BURST_W'(1)) begin
          in_burst <= 1'b0;
        end
      end
    end
  end

  // R1
  wr_left_chk: assert property (@(posedge clk) disable iff (rst) in_burst |-> (left != '0));
endmodule

// File: rtl/pbr_rd_ctrl.sv
`timescale 1ns/1ps
// Read burst server: takes one queued request at a time, issues one word per cycle.
module pbr_rd_ctrl #(
  parameter int AW      = 6,
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               q_empty,
  input  logic [AW-1:0]      q_addr,
  input  logic [BURST_W-1:0] q_len,
  output logic               q_pop,
  output logic               issue,
  output logic [AW-1:0]      issue_addr,
  output logic               serving,
  output logic               valid
);
  logic [BURST_W-1:0] left;

  assign q_pop = !serving && !q_empty;
  assign issue = serving;

  always_ff @(posedge clk) begin
    if (rst) begin
      serving    <= 1'b0;
      valid      <= 1'b0;
      left       <= '0;
      issue_addr <= '0;
    end else begin
      valid <= serving;
      if (q_pop) begin
        serving    <= 1'b1;
        issue_addr <= q_addr;
        left       <= q_len;
      end else if (serving) begin
        issue_addr <= issue_addr + AW'(1);
        left       <= left - BURST_W'(1);
        if (left == BURST_W'(1)) begin
          serving <= 1'b0;
        end
      end
    end
  end

  // R3
  rd_left_chk: assert property (@(posedge clk) disable iff (rst) serving |-> (left != '0));
endmodule

// File: rtl/pbus_burst_ram.sv
`timescale 1ns/1ps
module pbus_burst_ram #(
  parameter int DEPTH      = 64,
  parameter int BURST_W    = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int QW = AW + BURST_W,
  localparam int OW = BURST_W + $clog2(FIFO_DEPTH + 2) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        bus_addr,
  input  logic [BURST_W-1:0]   bus_burst,
  input  logic                 bus_read,
  input  logic                 bus_write,
  input  logic [31:0]          bus_wdata,
  input  logic [3:0]           bus_byte_en,
  output logic                 bus_wait,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid
);
  logic               wr_in_burst, rd_serving;
  logic               q_empty, q_full, q_pop;
  logic [QW-1:0]      q_head;
  logic [AW-1:0]      wr_addr, rd_addr;
  logic               rd_issue;
  logic               acc_rd, acc_wr;
  logic [BURST_W-1:0] rd_len;

  assign bus_wait = bus_read  ? (wr_in_burst || q_full)
                              : (bus_write && !wr_in_burst && (rd_serving || !q_empty));
  assign acc_rd   = bus_read  && !bus_wait;
  assign acc_wr   = bus_write && !bus_wait;
  assign rd_len   = (bus_burst == '0) ? BURST_W'(1) : bus_burst;

  pbr_wr_ctrl #(.AW(AW), .BURST_W(BURST_W)) u_wr (
    .clk(clk), .rst(rst), .fire(acc_wr), .addr(bus_addr), .burst(bus_burst),
    .beat_addr(wr_addr), .in_burst(wr_in_burst)
  );

  pbr_req_fifo #(.DEPTH(FIFO_DEPTH), .W(QW)) u_q (
    .clk(clk), .rst(rst), .push(acc_rd), .din({bus_addr, rd_len}),
    .pop(q_pop), .dout(q_head), .empty(q_empty), .full(q_full)
  );

  pbr_rd_ctrl #(.AW(AW), .BURST_W(BURST_W)) u_rd (
    .clk(clk), .rst(rst), .q_empty(q_empty),
    .q_addr(q_head[QW-1:BURST_W]), .q_len(q_head[BURST_W-1:0]),
    .q_pop(q_pop), .issue(rd_issue), .issue_addr(rd_addr),
    .serving(rd_serving), .valid(bus_rvalid)
  );

  pbr_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(acc_wr), .waddr(wr_addr), .wdata(bus_wdata), .wlanes(bus_byte_en),
    .re(rd_issue), .raddr(rd_addr), .rdata(bus_rdata)
  );

  // Beats still owed to the master, kept only to check the data-valid stream.
  logic [OW-1:0] owed;
  always_ff @(posedge clk) begin
    if (rst) begin
      owed <= '0;
    end else begin
      owed <= owed + (acc_rd ? OW'(rd_len) : OW'(0)) - OW'(bus_rvalid);
    end
  end

  // R3
  rvalid_owed_chk: assert property (@(posedge clk) disable iff (rst) bus_rvalid |-> (owed != '0));
  // R5
  rd_in_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_in_burst && bus_read) |-> !acc_rd);
endmodule

// File: tb/tb_pbus_burst_ram.sv
`timescale 1ns/1ps
module tb_pbus_burst_ram;
  localparam int DEPTH = 64;
  localparam int BW    = 4;
  localparam int FD    = 4;

  logic        clk = 0, rst = 1;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_burst = '0;
  logic        bus_read = 0, bus_write = 0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_byte_en = '0;
  logic        bus_wait, bus_rvalid;
  logic [31:0] bus_rdata;

  pbus_burst_ram #(.DEPTH(DEPTH), .BURST_W(BW), .FIFO_DEPTH(FD)) dut (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] model [DEPTH];
  logic [31:0] got[$];
  int          got_cyc[$];
  logic [31:0] exp_q[$];
  int checks = 0, fails = 0;

  always @(negedge clk) begin
    if (bus_rvalid) begin
      got.push_back(bus_rdata);
      got_cyc.push_back(cyc);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int s);
    return (32'h9E3779B9 * s) ^ 32'h00C0FFEE ^ (s << 20);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // one write strobe held until accepted; model updated at maddr
  task automatic wr_beat(input int a, input int n, input int maddr, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_write = 1; bus_addr = 6'(a); bus_burst = 4'(n); bus_wdata = d; bus_byte_en = be;
    #1;
    while (bus_wait) begin @(negedge clk); #1; end
    model[maddr] = merge(model[maddr], d, be);
    @(posedge clk);
  endtask

  task automatic wr_burst(input int a, input int n, input int seed);
    int beats = (n == 0) ? 1 : n;
    for (int b = 0; b < beats; b++) begin
      // later beats carry junk address/length that must be ignored (R1)
      wr_beat((b == 0) ? a : (a + 7*b + 3) % DEPTH, (b == 0) ? n : b + 5,
              (a + b) % DEPTH, pat(seed + b), 4'hF);
    end
    @(negedge clk); bus_write = 0;
  endtask

  task automatic rd_req(input int a, input int n, output int acc);
    int beats = (n == 0) ? 1 : n;
    @(negedge clk);
    bus_read = 1; bus_addr = 6'(a); bus_burst = 4'(n);
    #1;
    while (bus_wait) begin @(negedge clk); #1; end
    acc = cyc + 1;
    for (int i = 0; i < beats; i++) exp_q.push_back(model[(a + i) % DEPTH]);
    @(posedge clk);
    @(negedge clk); bus_read = 0;
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (got.size() < exp_q.size() && t < 400) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    check(got.size() == exp_q.size(), req, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check(got[i] === exp_q[i], req, got[i], exp_q[i]);
  endtask

  task automatic clear_q();
    got.delete(); got_cyc.delete(); exp_q.delete();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int acc, acc0, nacc, waited, k;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check(bus_wait == 0, "R9 wait", bus_wait, 0);
    check(bus_rvalid == 0, "R9 rvalid", bus_rvalid, 0);

    // R1 fill whole memory with bursts of 8
    for (int j = 0; j < DEPTH / 8; j++) wr_burst(8 * j, 8, 100 + 8 * j);
    // R3 read all back, check latency and contiguity
    for (int j = 0; j < DEPTH / 8; j++) begin
      rd_req(8 * j, 8, acc);
      if (j == 0) acc0 = acc;
      drain("R3 readback");
      check(got_cyc.size() == 8 && got_cyc[0] == acc + 2, "R3 first beat latency",
            (got_cyc.size() > 0) ? got_cyc[0] : -1, acc + 2);
      check(got_cyc.size() == 8 && got_cyc[7] == got_cyc[0] + 7, "R3 contiguous beats",
            (got_cyc.size() == 8) ? got_cyc[7] - got_cyc[0] : -1, 7);
      clear_q();
    end

    // R2 every byte-enable mask
    for (int be = 0; be < 16; be++) begin
      wr_beat(40 + be, 1, 40 + be, 32'h11223344 ^ (be * 32'h01010101), 4'(be));
    end
    @(negedge clk); bus_write = 0;
    rd_req(40, 8, acc); rd_req(48, 8, acc);
    drain("R2 byte enables"); clear_q();

    // R6 zero-length bursts
    wr_burst(5, 0, 900);
    wr_burst(9, 1, 901);
    rd_req(5, 0, acc);
    rd_req(4, 6, acc);
    drain("R6 zero burst"); clear_q();

    // R7 wrap-around
    wr_burst(62, 4, 950);
    rd_req(62, 4, acc);
    rd_req(60, 8, acc);
    drain("R7 wrap"); clear_q();

    // R4 outstanding reads fill the queue
    nacc = 0; waited = 0; acc0 = 0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      bus_read = 1; bus_addr = 6'(8 * nacc); bus_burst = 4'd8;
      #1;
      if (!bus_wait) begin
        if (nacc == 0) acc0 = cyc + 1;
        for (int i = 0; i < 8; i++) exp_q.push_back(model[8 * nacc + i]);
        nacc++;
      end else begin
        waited++;
      end
      @(posedge clk);
    end
    @(negedge clk); bus_read = 0;
    check(nacc == FD + 1, "R4 accepted before full", nacc, FD + 1);
    check(waited == 1, "R4 wait when full", waited, 1);
    drain("R4 order");
    check(got_cyc.size() == 40 && got_cyc[7] == acc0 + 9, "R4 first burst end",
          (got_cyc.size() > 7) ? got_cyc[7] : -1, acc0 + 9);
    check(got_cyc.size() == 40 && got_cyc[8] == got_cyc[7] + 2, "R4 one idle cycle between bursts",
          (got_cyc.size() > 8) ? got_cyc[8] - got_cyc[7] : -1, 2);
    clear_q();

    // R5 read waited during a write burst
    wr_beat(10, 3, 10, pat(70), 4'hF);
    @(negedge clk);
    bus_write = 0; bus_read = 1; bus_addr = 6'd0; bus_burst = 4'd1;
    #1;
    check(bus_wait == 1, "R5 read during write burst", bus_wait, 1);
    @(negedge clk); bus_read = 0;
    wr_beat(33, 9, 11, pat(71), 4'hF);
    wr_beat(34, 9, 12, pat(72), 4'hF);
    @(negedge clk); bus_write = 0;
    // R5 new write waited while reads pending
    rd_req(10, 8, acc);
    @(negedge clk);
    bus_write = 1; bus_addr = 6'd50; bus_burst = 4'd1; bus_wdata = pat(73); bus_byte_en = 4'hF;
    #1;
    check(bus_wait == 1, "R5 write while reads pending", bus_wait, 1);
    while (bus_wait) begin @(negedge clk); #1; end
    k = cyc + 1;
    model[50] = pat(73);
    @(posedge clk);
    @(negedge clk); bus_write = 0;
    check(k == acc + 10, "R5 write accepted after reads done", k, acc + 10);
    drain("R5 data"); clear_q();
    rd_req(50, 1, acc);
    drain("R5 written word"); clear_q();

    // R8 reset aborts write burst, keeps memory
    wr_beat(20, 4, 20, pat(80), 4'hF);
    wr_beat(0, 0, 21, pat(81), 4'hF);
    @(negedge clk); bus_write = 0; rst = 1;
    @(negedge clk); rst = 0;
    wr_burst(30, 1, 82);
    rd_req(20, 4, acc);
    rd_req(30, 1, acc);
    drain("R8 write abort"); clear_q();

    // R8 reset during reads
    rd_req(0, 8, acc);
    rd_req(8, 8, acc);
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    check(bus_rvalid == 0, "R8 rvalid cleared", bus_rvalid, 0);
    rst = 0;
    clear_q();
    repeat (25) @(negedge clk);
    check(got.size() == 0, "R8 queue emptied", got.size(), 0);
    check(bus_wait == 0, "R8 idle after reset", bus_wait, 0);
    rd_req(0, 8, acc);
    drain("R8 memory kept"); clear_q();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule